// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block brings an asynchronous DRAM out of power-up and keeps it refreshed. After reset it holds every strobe inactive for a programmed pause. It then runs a burst of wake-up refresh cycles, which need no bus grant. When the burst ends it raises `init_done`. From then on an interval timer adds one outstanding refresh every `INTERVAL_CYC` clocks. The interval is sized so that the full row space is covered within the retention window.

Each outstanding refresh raises `req` towards the access controller and waits for `grant`. It then runs as a CAS-before-RAS cycle on the DRAM strobes. Both byte CAS lines fall first, RAS follows, and WE stays high. The DRAM's own row counter picks the row, so no address is driven. Requests that are not serviced pile up to a limit, and `urgent` marks the limit. If another interval expires while the limit is reached, the refresh deadline counts as missed. `init_done` then drops, and the wake-up burst is run again after the next grant.

The sequencer has six states:
- PAUSE counts the power-up delay.
- IDLE waits for an outstanding refresh or a pending re-wake.
- WAIT holds `req` until `grant`.
- SETUP drives CAS low with RAS high.
- STROBE drives RAS and CAS low.
- PRECH returns all strobes high.

Its transitions are:
- PAUSE goes to SETUP when the pause counter expires, and this starts the burst.
- IDLE goes to WAIT on an outstanding request or a re-wake.
- WAIT goes to SETUP on `grant`.
- SETUP goes to STROBE when its counter expires.
- STROBE goes to PRECH when its counter expires.
- PRECH goes back to SETUP while burst cycles remain. Otherwise it goes to IDLE.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset, `ras_n`, `cas_lo_n`, `cas_hi_n` and `we_n` are 1, and `req`, `urgent`, `busy` and `init_done` are 0.
- R2: After reset is released, exactly `PAUSE_CYC` clock cycles pass with CAS high before CAS first falls.
- R3: Exactly `WAKE_CNT` RAS pulses occur while `init_done` is 0, with no grant required, before `init_done` rises.
- R4: In every refresh, CAS is low for exactly `SETUP_CYC` cycles before RAS falls. CAS stays low whenever RAS is low. `cas_lo_n` equals `cas_hi_n` at all times, and `we_n` is always 1.
- R5: RAS stays low for exactly `LOW_CYC` cycles per pulse, and stays high for at least `PRE_CYC` cycles between pulses.
- R6: `req` first rises `INTERVAL_CYC+1` cycles after `init_done` rises. With prompt grants it then rises every `INTERVAL_CYC` cycles. No strobe moves while `req` waits without `grant`.
- R7: `urgent` is 1 exactly when `POSTPONE+1` refreshes are outstanding. Without grants this happens `2*INTERVAL_CYC` cycles after `init_done` rises when `POSTPONE` is 1.
- R8: An interval that expires while `POSTPONE+1` refreshes are outstanding clears `init_done` at that edge and leaves `req` high. After `grant`, a new burst of `WAKE_CNT` pulses runs, and then `init_done` rises again.
- R9: `busy` is 1 whenever any strobe is low.
- R10: Once granted, all outstanding refreshes run back to back. `urgent` and `req` are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Access controller hands the DRAM bus to the scheduler |
| req | output | 1 | Scheduler asks for the bus |
| urgent | output | 1 | Postponement limit reached |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| busy | output | 1 | Refresh strobe sequence in progress |
| init_done | output | 1 | Wake-up sequence complete, accesses allowed |

## Verification
The bench uses a small configuration with a 20-cycle pause, a 40-cycle interval and a postponement limit of one. It drives four grant patterns.
- No grant after power-up separates the grant-free wake-up burst from granted refreshes.
- A grant withheld for three intervals shows when `urgent` appears and when the deadline miss occurs, each exact to the cycle.
- A grant held high measures the request spacing.
- A grant released while two refreshes are outstanding checks that both run back to back.

A monitor times every strobe edge against the setup, low-time and precharge counts.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_STROBE,
        ST_PRECH
    } rf_state_t;
endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic done,
    output logic pending,
    output logic urgent,
    output logic miss
);
    localparam int CW = $clog2(INTERVAL_CYC);
    localparam int PW = $clog2(MAX_PEND + 1);

    logic [CW-1:0] cnt;
    logic [PW-1:0] pend;
    logic          tick;

    assign tick    = run && (cnt == CW'(INTERVAL_CYC - 1));
    assign miss    = tick && (pend == PW'(MAX_PEND));
    assign pending = (pend != '0);
    assign urgent  = (pend == PW'(MAX_PEND));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || miss) begin
            pend <= '0;
        end else if (tick && !(done && pending)) begin
            pend <= pend + 1'b1;
        end else if (!tick && done && pending) begin
            pend <= pend - 1'b1;
        end
    end

    // R7: the outstanding count never passes its limit
    p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(MAX_PEND));

    // R8: a miss always leaves the counter empty
    p_miss_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !pending);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CYC = 20000,
    parameter int WAKE_CNT  = 8,
    parameter int SETUP_CYC = 1,
    parameter int LOW_CYC   = 5,
    parameter int PRE_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic grant,
    input  logic miss,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic init_done,
    output logic done
);
    localparam int M1 = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
    localparam int M2 = (M1 > PRE_CYC) ? M1 : PRE_CYC;
    localparam int MX = (M2 > PAUSE_CYC) ? M2 : PAUSE_CYC;
    localparam int TW = $clog2(MX + 1);
    localparam int WW = $clog2(WAKE_CNT + 1);

    rf_state_t     state;
    logic [TW-1:0] tmr;
    logic [WW-1:0] wake_left;
    logic          waking;
    logic          rewake;

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PAUSE;
            tmr       <= TW'(PAUSE_CYC - 1);
            wake_left <= '0;
            waking    <= 1'b0;
            rewake    <= 1'b0;
            init_done <= 1'b0;
        end else begin
            if (miss) begin
                init_done <= 1'b0;
                rewake    <= 1'b1;
            end
            unique case (state)
                ST_PAUSE: begin
                    if (tmr == '0) begin
                        state     <= ST_SETUP;
                        tmr       <= TW'(SETUP_CYC - 1);
                        waking    <= 1'b1;
                        wake_left <= WW'(WAKE_CNT);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (pending || rewake || miss) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (grant) begin
                        state <= ST_SETUP;
                        tmr   <= TW'(SETUP_CYC - 1);
                        if (rewake || miss) begin
                            waking    <= 1'b1;
                            wake_left <= WW'(WAKE_CNT);
                            rewake    <= 1'b0;
                        end
                    end
                end
                ST_SETUP: begin
                    if (tmr == '0) begin
                        state <= ST_STROBE;
                        tmr   <= TW'(LOW_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (tmr == '0) begin
                        state <= ST_PRECH;
                        tmr   <= TW'(PRE_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (tmr == '0) begin
                        if (waking && wake_left > WW'(1)) begin
                            wake_left <= wake_left - 1'b1;
                            state     <= ST_SETUP;
                            tmr       <= TW'(SETUP_CYC - 1);
                        end else begin
                            state <= ST_IDLE;
                            if (waking) begin
                                waking    <= 1'b0;
                                init_done <= 1'b1;
                            end
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // output decode
    always_comb begin
        req   = (state == ST_WAIT);
        cas_n = !((state == ST_SETUP) || (state == ST_STROBE));
        ras_n = (state != ST_STROBE);
        busy  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_PRECH);
        done  = (state == ST_PRECH) && (tmr == '0) && !waking;
    end

    // R4: RAS only falls after CAS was already low
    p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R6: no strobe activity while waiting for the bus
    p_req_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (ras_n && cas_n));

    // R9: busy covers every low strobe
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n || !ras_n) |-> busy);

    // R3: init completes only out of a precharge phase
    p_init_after_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(state) == ST_PRECH));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int PAUSE_CYC    = 20000,
    parameter int WAKE_CNT     = 8,
    parameter int SETUP_CYC    = 1,
    parameter int LOW_CYC      = 5,
    parameter int PRE_CYC      = 3,
    parameter int INTERVAL_CYC = 1560,
    parameter int POSTPONE     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic req,
    output logic urgent,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic we_n,
    output logic busy,
    output logic init_done
);
    localparam int MAX_PEND = POSTPONE + 1;

    logic pending;
    logic miss;
    logic done;
    logic cas_n;

    rfsh_interval #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .MAX_PEND    (MAX_PEND)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (init_done),
        .done   (done),
        .pending(pending),
        .urgent (urgent),
        .miss   (miss)
    );

    rfsh_seq #(
        .PAUSE_CYC(PAUSE_CYC),
        .WAKE_CNT (WAKE_CNT),
        .SETUP_CYC(SETUP_CYC),
        .LOW_CYC  (LOW_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pending),
        .grant    (grant),
        .miss     (miss),
        .req      (req),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .busy     (busy),
        .init_done(init_done),
        .done     (done)
    );

    assign cas_lo_n = cas_n;
    assign cas_hi_n = cas_n;
    assign we_n     = 1'b1;

    // R8: a missed deadline withdraws init_done at once
    p_miss_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !init_done);

    // R4: RAS low never occurs with a CAS line high
    p_ras_needs_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (!cas_lo_n && !cas_hi_n));
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int P  = 20;
    localparam int W  = 8;
    localparam int S  = 1;
    localparam int L  = 5;
    localparam int R  = 3;
    localparam int I  = 40;
    localparam int PP = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic req, urgent, ras_n, cas_lo_n, cas_hi_n, we_n, busy, init_done;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    dram_refresh_sched #(
        .PAUSE_CYC(P), .WAKE_CNT(W), .SETUP_CYC(S), .LOW_CYC(L),
        .PRE_CYC(R), .INTERVAL_CYC(I), .POSTPONE(PP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .urgent(urgent),
        .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n),
        .busy(busy), .init_done(init_done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    endtask

    // strobe monitor
    bit prev_ras = 1'b1, prev_init = 1'b0, prev_req = 1'b0;
    bit first_cas_seen = 1'b0, first_req = 1'b0, spacing_en = 1'b1;
    int pre_cnt = 0, setup_run = 0, low_run = 0, hi_run = 0;
    int wake_falls = 0, ras_falls_total = 0, t0 = 0, last_req = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!first_cas_seen) begin
                if (cas_lo_n) pre_cnt++;
                else begin
                    first_cas_seen = 1'b1;
                    chk("R2 pause length", pre_cnt == P, pre_cnt, P);
                end
            end
            if (we_n !== 1'b1 || cas_lo_n !== cas_hi_n)
                chk("R4 we high and byte CAS paired", 1'b0, {we_n, cas_lo_n, cas_hi_n}, 3'b100);
            if (!ras_n && prev_ras) begin
                chk("R4 CAS setup before RAS", setup_run == S, setup_run, S);
                if (ras_falls_total > 0) chk("R5 precharge", hi_run >= R, hi_run, R);
                ras_falls_total++;
                if (!init_done) wake_falls++;
            end
            if (!ras_n) begin
                if (cas_lo_n) chk("R4 CAS low under RAS", 1'b0, 1, 0);
                low_run++;
                hi_run = 0;
            end else begin
                if (!prev_ras) begin
                    chk("R5 RAS low width", low_run == L, low_run, L);
                    low_run = 0;
                end
                hi_run++;
            end
            if (!cas_lo_n && ras_n) setup_run++;
            else if (cas_lo_n) setup_run = 0;
            if ((!ras_n || !cas_lo_n) && !busy) chk("R9 busy with strobe low", 1'b0, 0, 1);
            if (init_done && !prev_init) begin
                chk("R3 wake pulse count", wake_falls == W, wake_falls, W);
                wake_falls = 0;
                t0 = cyc;
                first_req = 1'b1;
            end
            if (!init_done && prev_init) wake_falls = 0;
            if (req && !prev_req && init_done && spacing_en) begin
                if (first_req) chk("R6 first request delay", cyc - t0 == I + 1, cyc - t0, I + 1);
                else chk("R6 request spacing", cyc - last_req == I, cyc - last_req, I);
                last_req = cyc;
                first_req = 1'b0;
            end
            prev_ras = ras_n;
            prev_init = init_done;
            prev_req = req;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1'b0, cyc, 0);
        finish_run();
    end

    initial begin
        int tm;
        int snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset strobes", {ras_n, cas_lo_n, cas_hi_n, we_n} == 4'hF,
            {ras_n, cas_lo_n, cas_hi_n, we_n}, 15);
        chk("R1 reset flags", {req, urgent, busy, init_done} == 4'h0,
            {req, urgent, busy, init_done}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // power-up with no grant at all
        while (!init_done) begin @(negedge clk); #1; end
        tm = cyc;
        snap = ras_falls_total;
        chk("R7 urgent low at init", urgent == 1'b0, urgent, 0);
        while (!urgent) begin @(negedge clk); #1; end
        chk("R7 urgent timing", cyc - tm == 2 * I, cyc - tm, 2 * I);
        chk("R6 no strobe without grant", ras_falls_total == snap, ras_falls_total, snap);
        while (init_done) begin @(negedge clk); #1; end
        chk("R8 miss timing", cyc - tm == 3 * I, cyc - tm, 3 * I);
        chk("R8 request held", req == 1'b1, req, 1);
        chk("R8 urgent cleared by miss", urgent == 1'b0, urgent, 0);

        // grant: re-wake burst then steady requests
        grant = 1'b1;
        while (!init_done) begin @(negedge clk); #1; end
        chk("R8 init back after burst", init_done == 1'b1, init_done, 1);
        repeat (5 * I) begin @(negedge clk); #1; end
        chk("R10 no backlog with prompt grant", urgent == 1'b0, urgent, 0);

        // two outstanding then release
        spacing_en = 1'b0;
        grant = 1'b0;
        while (!urgent) begin @(negedge clk); #1; end
        snap = ras_falls_total;
        grant = 1'b1;
        repeat (30) begin @(negedge clk); #1; end
        chk("R10 back-to-back refreshes", ras_falls_total - snap == 2, ras_falls_total - snap, 2);
        chk("R10 urgent cleared", urgent == 1'b0, urgent, 0);
        chk("R10 request idle", req == 1'b0, req, 0);
        chk("R10 init kept", init_done == 1'b1, init_done, 1);
        finish_run();
    end
endmodule